// File: doc/BRIEF.md
# Bit-Select Reset PWM Timer

This block is a single-channel pulse-width modulator driven by one free-running 8-bit counter. The counter advances on each cycle in which a 32 kHz clock-enable input is high. The period is not set by a period register. A 2-bit prescaler picks one counter bit, and as soon as that bit would become set the counter returns to zero. A slower rate therefore keeps more low counter bits for the duty comparison, and a faster rate keeps fewer.

Software programs two byte-wide registers through a small synchronous write port. The read data is combinational. The control register at address 0 carries the output enable in bit 7 and the prescaler in bits 1:0. The duty register at address 1 carries a 7-bit tick count. The output is high while the counter's usable low bits are below the duty value.

Writes take effect immediately. A new prescaler does not clear the counter, and a new duty value acts in the middle of a period. Firmware must order its writes to avoid glitches.

Top module: `pwmt_top`

## Requirements
- R1: A synchronous active-high reset clears both registers and the counter. After reset, both registers read 0 and the output is low.
- R2: Control reads back bit 7 (enable) and bits 1:0 (prescaler) as written, and bits 6:2 read 0. Duty reads back its low 7 bits as written, and bit 7 reads 0.
- R3: While enable is clear, the output is low and the counter is held at zero. After enable is set, counting starts from zero, so the output is high for exactly the first duty ticks.
- R4: With prescaler p and duty d, where 0 < d < 2^(7-p), the output is high for exactly d of every 2^(7-p) ticks.
- R5: Prescaler values 0, 1, 2 and 3 give periods of 128, 64, 32 and 16 ticks. These come from resetting the counter when bit 7, 6, 5 or 4 would become set.
- R6: A duty of 0 keeps the output low.
- R7: A duty equal to 2^(7-p) keeps the output high for prescalers 1 to 3. With prescaler 0, the largest duty of 127 gives 127 high ticks out of 128.
- R8: Writing a new prescaler does not clear the counter. The counter runs on and resets only when the newly selected bit would become set.
- R9: A duty write changes the output within the current period, without waiting for the period boundary.
- R10: A duty larger than the current full scale leaves the output at a defined 0 or 1, never unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32 kHz count enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data of the register selected by addr |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The duty comparison is tested at every prescaler with duties at 0, at 1, at mid values, at 127 and at full scale. These runs separate a correct bit mask from an off-by-one compare, and a correct period from a wrong reset bit. A prescaler switch while the counter sits at 100 produces a pattern that differs from the one a cleared counter would produce. A duty raise in mid-period shows whether the write acts immediately or waits for the boundary. The enable-from-idle pattern confirms that counting starts from zero.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int CNT_W  = 8;
    localparam int PSC_W  = 2;
    localparam int DUTY_W = CNT_W - 1;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 1;
    localparam int EN_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);

    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    // Counter value at which the selected bit first becomes set (full scale).
    function automatic logic [CNT_W-1:0] full_scale(input logic [PSC_W-1:0] p);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        return one << (CNT_W - 1 - int'(p));
    endfunction

    // Usable low counter bits for a prescaler.
    function automatic logic [CNT_W-1:0] low_mask(input logic [PSC_W-1:0] p);
        return full_scale(p) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [DUTY_W-1:0] duty_q,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                ctrl_q.en  <= wdata[EN_BIT];
                ctrl_q.psc <= wdata[PSC_W-1:0];
            end else begin
                duty_q <= wdata[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[EN_BIT]      = ctrl_q.en;
            rdata[PSC_W-1:0]   = ctrl_q.psc;
        end else begin
            rdata[DUTY_W-1:0]  = duty_q;
        end
    end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        hit     = |(cnt_inc & full_scale(ctrl.psc));
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare
    import pwmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  cnt,
    output logic              pwm_q
);

    logic [CNT_W-1:0] low_bits;
    logic             want_high;

    always_comb begin
        low_bits  = cnt & low_mask(ctrl.psc);
        want_high = ctrl.en && ({1'b0, duty} > low_bits);
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= want_high;
    end

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
    import pwmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);

    ctrl_t             ctrl_q;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W-1:0]  cnt_q;

    pwmt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .duty_q (duty_q),
        .rdata  (rdata)
    );

    pwmt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .ctrl  (ctrl_q),
        .cnt_q (cnt_q)
    );

    pwmt_compare u_cmp (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl_q),
        .duty  (duty_q),
        .cnt   (cnt_q),
        .pwm_q (pwm_out)
    );

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm_out,
    input ctrl_t             ctrl_q,
    input logic [DUTY_W-1:0] duty_q,
    input logic [CNT_W-1:0]  cnt_q
);

    logic [CNT_W-1:0] full;
    logic             ctrl_wr;

    always_comb begin
        full    = full_scale(ctrl_q.psc);
        ctrl_wr = wr_en && (addr == ADDR_CTRL);
    end

    assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_CTRL) |-> (rdata[EN_BIT-1:PSC_W] == '0));

    assert_duty_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_DUTY) |-> (rdata[DATA_W-1] == 1'b0));

    assert_off_low_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |=> (!pwm_out && cnt_q == '0));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && cnt_q < full && !ctrl_wr) |=> (cnt_q < full));

    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |=> !pwm_out);

    assert_full_high_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && {1'b0, duty_q} == full && cnt_q < full) |=> pwm_out);

endmodule

bind pwmt_top pwmt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .pwm_out (pwm_out),
    .ctrl_q  (ctrl_q),
    .duty_q  (duty_q),
    .cnt_q   (cnt_q)
);

// File: tb/sim_pwmt_top.sv
module sim_pwmt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwmt_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(output bit h);
        @(negedge clk);
        @(negedge clk);
        h = pwm_out;
    endtask

    task automatic step(output bit h);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        h = pwm_out;
    endtask

    function automatic bit model_high(input int c, input int p, input int d);
        int full = 1 << (7 - p);
        return (c % full) < d;
    endfunction

    // Start from a cleared counter with prescaler p and duty d.
    task automatic start(input int p, input int d);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'(d));
        wr(1'b0, 8'h80 | 8'(p));
    endtask

    task automatic count_period(input int p, input int d, input string req);
        int full = 1 << (7 - p);
        int highs = 0;
        bit h;
        start(p, d);
        settle(h);
        highs += int'(h);
        for (int k = 1; k < full; k++) begin
            step(h);
            highs += int'(h);
        end
        chk(highs == d, req, highs, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk(v == 8'h00, "R1 ctrl after reset", v, 0);
        rd(1'b1, v); chk(v == 8'h00, "R1 duty after reset", v, 0);
        chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(1'b0, 8'hFF); rd(1'b0, v); chk(v == 8'h83, "R2 ctrl pad bits", v, 8'h83);
        wr(1'b0, 8'h02); rd(1'b0, v); chk(v == 8'h02, "R2 ctrl value", v, 8'h02);
        wr(1'b1, 8'hFF); rd(1'b1, v); chk(v == 8'h7F, "R2 duty bit7", v, 8'h7F);
        wr(1'b1, 8'h55); rd(1'b1, v); chk(v == 8'h55, "R2 duty value", v, 8'h55);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_disabled_then_enable();
        bit h;
        int bad = 0;
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h03);
        for (int k = 0; k < 20; k++) begin
            step(h);
            if (h) bad++;
        end
        chk(bad == 0, "R3 low while disabled", bad, 0);
        wr(1'b0, 8'h83);
        bad = 0;
        settle(h);
        if (h != model_high(0, 3, 3)) bad++;
        for (int k = 1; k < 16; k++) begin
            step(h);
            if (h != model_high(k, 3, 3)) bad++;
        end
        chk(bad == 0, "R3 counting starts at zero", bad, 0);
    endtask

    task automatic t_duty_ratio();
        count_period(0, 37, "R4 p0 duty 37");
        count_period(1, 1, "R4 p1 duty 1");
        count_period(2, 31, "R4 p2 duty 31");
        count_period(3, 5, "R4 p3 duty 5");
    endtask

    task automatic t_period();
        bit h;
        for (int p = 0; p < 4; p++) begin
            int full = 1 << (7 - p);
            int highs = 0;
            int second = -1;
            start(p, 1);
            settle(h);
            highs += int'(h);
            for (int k = 1; k < 2 * full; k++) begin
                step(h);
                if (h) begin
                    highs++;
                    if (k != 0 && second < 0) second = k;
                end
            end
            chk(highs == 2 && second == full, "R5 period length", second, full);
        end
    endtask

    task automatic t_extremes();
        count_period(2, 0, "R6 duty 0 stays low");
        count_period(1, 64, "R7 p1 full scale high");
        count_period(3, 16, "R7 p3 full scale high");
        count_period(0, 127, "R7 p0 duty 127");
    endtask

    task automatic t_psc_switch();
        bit h;
        bit [12:0] got;
        bit [12:0] exp;
        start(0, 8);
        settle(h);
        for (int k = 1; k <= 100; k++) step(h);
        wr(1'b0, 8'h83);
        settle(h);
        got[0] = h;
        exp[0] = ((100 % 16) < 8);
        for (int k = 1; k <= 12; k++) begin
            int v = 100 + k;
            if (v >= 112) v = 0;
            step(h);
            got[k] = h;
            exp[k] = ((v % 16) < 8);
        end
        chk(got == exp, "R8 counter kept on prescaler change", int'(got), int'(exp));
    endtask

    task automatic t_duty_mid();
        bit h;
        start(1, 10);
        settle(h);
        for (int k = 1; k <= 20; k++) step(h);
        chk(h == 1'b0, "R9 before duty raise", h, 0);
        wr(1'b1, 8'd40);
        settle(h);
        chk(h == 1'b1, "R9 duty raise mid-period", h, 1);
        wr(1'b1, 8'd5);
        settle(h);
        chk(h == 1'b0, "R9 duty drop mid-period", h, 0);
    endtask

    task automatic t_over_scale();
        bit h;
        int unk = 0;
        start(3, 100);
        settle(h);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
            if ($isunknown(pwm_out)) unk++;
        end
        chk(unk == 0, "R10 no unknown output", unk, 0);
    endtask

    task automatic t_mid_reset();
        logic [7:0] v;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        rd(1'b0, v); chk(v == 8'h00, "R1 ctrl after mid-run reset", v, 0);
        rd(1'b1, v); chk(v == 8'h00, "R1 duty after mid-run reset", v, 0);
        chk(pwm_out == 1'b0, "R1 output after mid-run reset", pwm_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_disabled_then_enable();
        t_duty_ratio();
        t_period();
        t_extremes();
        t_psc_switch();
        t_duty_mid();
        t_over_scale();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule